// File: doc/BRIEF.md
# Four-Phase Clock-Enable Generator

This block divides a repeating processor cycle into four steps, run in a fixed order: memory request, data capture, compute and write-back. It does this without making any new clock. A small sequencer runs on the single system clock. A bank of flip-flops turns the sequencer state into one enable strobe per step. Every downstream register stays on the same clock and uses its strobe as a clock enable, so the design keeps one clock domain and needs no derived or gated clocks.

The strobes come straight from flip-flops. Downstream logic therefore gets the whole clock period to use them. The block also outputs a small index that names the step whose strobe is high. A synchronous reset holds all strobes low. The first cycle after reset is always step 0. The number of steps is a parameter, with a default of four. A second parameter chooses how the sequencer is built: a wrapping binary counter or a circulating one-hot token. The two choices behave the same at the ports.

Top module: `phase_enable_gen`

## Requirements
- R1: At power-up, and on every cycle that follows a clock edge where `rst` was sampled high, `phase_en` is all zeros and `phase_idx` is 0.
- R2: On the first clock edge where `rst` is sampled low after a reset, the block raises bit 0 of `phase_en` (the memory-request step) and sets `phase_idx` to 0. No idle cycle comes first.
- R3: Outside reset, the high strobe moves from bit k to bit (k+1) mod NUM_PHASES on each clock edge, giving the order 0, 1, 2, 3, 0 with the default of four.
- R4: Outside reset, exactly one bit of `phase_en` is high in every cycle.
- R5: During an uninterrupted run, each bit of `phase_en` is high exactly once every NUM_PHASES cycles.
- R6: `phase_idx` holds the binary position of the high bit of `phase_en`. It never holds the internal sequencer state, which is one cycle ahead.
- R7: If `rst` is asserted mid-sequence, in any step, all strobes clear on the next edge. Once `rst` is released, the sequence starts again at step 0.
- R8: SEQ_STYLE 0 (binary counter) and SEQ_STYLE 1 (one-hot ring) produce the same `phase_en` and `phase_idx` on every cycle for the same `rst` stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phase_en | output | NUM_PHASES | Registered one-hot step strobes, bit 0 is the memory-request step |
| phase_idx | output | $clog2(NUM_PHASES) | Index of the step whose strobe is currently high |

## Verification
A sequencer state that is wrong shows up at the ports one edge later. The strobe vector then shows a skipped or repeated step, two bits high, or no bit high. The index would also stop matching the high bit. An off-by-one reset preload shows up at the first edge after release, because bit 0 would not be the strobe that rises. A reset path that ignores the current step shows up as a strobe still high on the cycle after a mid-sequence reset. The bench runs both sequencer styles side by side against one behavioural model, so a fault in either style differs from the model on the cycle it first reaches the ports.

// File: rtl/phase_gen_pkg.sv
package phase_gen_pkg;

   typedef enum logic [0:0] {
      SEQ_BINARY = 1'b0,
      SEQ_RING   = 1'b1
   } seq_style_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/phase_sequencer.sv
module phase_sequencer
   import phase_gen_pkg::*;
#(
   parameter int         NUM_PHASES = 4,
   parameter seq_style_e SEQ_STYLE  = SEQ_BINARY,
   localparam int        IW         = idx_width(NUM_PHASES)
) (
   input  logic                  clk,
   input  logic                  rst,
   output logic [NUM_PHASES-1:0] cur_oh,
   output logic [IW-1:0]         cur_idx
);

   localparam logic [IW-1:0] LAST_IDX = IW'(NUM_PHASES - 1);

   generate
      if (SEQ_STYLE == SEQ_BINARY) begin : g_binary
         logic [IW-1:0] cnt_q = '0;

         always_ff @(posedge clk) begin
            if (rst)                    cnt_q <= '0;
            else if (cnt_q == LAST_IDX) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
         end

         always_comb begin
            cur_oh = '0;
            for (int k = 0; k < NUM_PHASES; k++)
               cur_oh[k] = (cnt_q == IW'(k));
         end
         assign cur_idx = cnt_q;

         // R3
         cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_q <= LAST_IDX));
      end else begin : g_ring
         logic [NUM_PHASES-1:0] tok_q = NUM_PHASES'(1);

         always_ff @(posedge clk) begin
            if (rst) tok_q <= NUM_PHASES'(1);
            else     tok_q <= {tok_q[NUM_PHASES-2:0], tok_q[NUM_PHASES-1]};
         end

         always_comb begin
            cur_idx = '0;
            for (int k = 0; k < NUM_PHASES; k++)
               if (tok_q[k]) cur_idx = cur_idx | IW'(k);
         end
         assign cur_oh = tok_q;

         // R4
         token_onehot_chk: assert property (@(posedge clk)
            $onehot(tok_q));
      end
   endgenerate

endmodule

// File: rtl/phase_strobe_bank.sv
module phase_strobe_bank
   import phase_gen_pkg::*;
#(
   parameter int  NUM_PHASES = 4,
   localparam int IW         = idx_width(NUM_PHASES)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_PHASES-1:0] nxt_oh,
   input  logic [IW-1:0]         nxt_idx,
   output logic [NUM_PHASES-1:0] en_q,
   output logic [IW-1:0]         idx_q
);

   logic [NUM_PHASES-1:0] en_r  = '0;
   logic [IW-1:0]         idx_r = '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_r  <= '0;
         idx_r <= '0;
      end else begin
         en_r  <= nxt_oh;
         idx_r <= nxt_idx;
      end
   end

   assign en_q  = en_r;
   assign idx_q = idx_r;

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (en_q == '0 && idx_q == '0));

   // R7
   midrst_clear_chk: assert property (@(posedge clk)
      (rst && (en_q != '0)) |=> (en_q == '0));

   // R2
   release_chk: assert property (@(posedge clk)
      $fell(rst) |=> (en_q == NUM_PHASES'(1) && idx_q == '0));

endmodule

// File: rtl/phase_enable_gen.sv
module phase_enable_gen
   import phase_gen_pkg::*;
#(
   parameter int         NUM_PHASES = 4,
   parameter seq_style_e SEQ_STYLE  = SEQ_BINARY,
   localparam int        IW         = idx_width(NUM_PHASES)
) (
   input  logic                  clk,
   input  logic                  rst,
   output logic [NUM_PHASES-1:0] phase_en,
   output logic [IW-1:0]         phase_idx
);

   generate
      if (NUM_PHASES < 2) begin : g_bad_n
         $error("phase_enable_gen: NUM_PHASES must be at least 2");
      end
      if (NUM_PHASES > 64) begin : g_big_n
         $error("phase_enable_gen: NUM_PHASES above 64 not supported");
      end
   endgenerate

   logic [NUM_PHASES-1:0] seq_oh;
   logic [IW-1:0]         seq_idx;

   phase_sequencer #(
      .NUM_PHASES (NUM_PHASES),
      .SEQ_STYLE  (SEQ_STYLE)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .cur_oh  (seq_oh),
      .cur_idx (seq_idx)
   );

   phase_strobe_bank #(
      .NUM_PHASES (NUM_PHASES)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .nxt_oh  (seq_oh),
      .nxt_idx (seq_idx),
      .en_q    (phase_en),
      .idx_q   (phase_idx)
   );

   // R4
   onehot_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_en != '0) |=> $onehot(phase_en));

   // R3
   order_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_en != '0) |=>
         (phase_en == {$past(phase_en[NUM_PHASES-2:0]), $past(phase_en[NUM_PHASES-1])}));

   // R6
   idx_match_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_en != '0) |-> phase_en[phase_idx]);

endmodule

// File: tb/sim_phase_enable_gen.sv
module sim_phase_enable_gen;
   import phase_gen_pkg::*;

   localparam int N  = 4;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0]  en0, en1;
   logic [IW-1:0] idx0, idx1;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   phase_enable_gen #(.NUM_PHASES(N), .SEQ_STYLE(SEQ_BINARY)) u0 (
      .clk(clk), .rst(rst), .phase_en(en0), .phase_idx(idx0));
   phase_enable_gen #(.NUM_PHASES(N), .SEQ_STYLE(SEQ_RING)) u1 (
      .clk(clk), .rst(rst), .phase_en(en1), .phase_idx(idx1));

   // behavioural reference model
   int     m_cnt = 0;
   bit     m_run = 0;
   bit     m_first = 0;
   bit     m_mid = 0;
   logic [N-1:0]  exp_en = '0;
   logic [IW-1:0] exp_idx = '0;
   int     last_hi [N];

   initial for (int k = 0; k < N; k++) last_hi[k] = -1;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (rst) begin
         m_mid   = m_run;
         m_run   = 0;
         m_first = 0;
         m_cnt   = 0;
         exp_en  = '0;
         exp_idx = '0;
         for (int k = 0; k < N; k++) last_hi[k] = -1;
      end else begin
         m_first = !m_run;
         m_mid   = 0;
         m_run   = 1;
         exp_en  = '0;
         exp_en[m_cnt] = 1'b1;
         exp_idx = IW'(m_cnt);
         m_cnt   = (m_cnt + 1) % N;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done && cyc > 0) begin
         string t;
         if (!m_run)       t = m_mid ? "R7" : "R1";
         else if (m_first) t = "R2";
         else              t = "R3";
         chk({t, " en u0"}, 32'(en0), 32'(exp_en));
         chk({t, " idx u0"}, 32'(idx0), 32'(exp_idx));
         chk("R8 en u1", 32'(en1), 32'(exp_en));
         chk("R8 idx u1", 32'(idx1), 32'(exp_idx));
         if (m_run) begin
            chk("R4 onehot", 32'($countones(en0)), 32'd1);
            for (int k = 0; k < N; k++) begin
               if (en0[k]) begin
                  chk("R6 idx position", 32'(idx0), 32'(k));
                  if (last_hi[k] >= 0) chk("R5 period", 32'(cyc - last_hi[k]), 32'(N));
                  last_hi[k] = cyc;
               end
            end
         end
      end
   end

   task automatic run(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #1;
      chk("R1 power-up en", 32'(en0), 32'd0);
      chk("R1 power-up idx", 32'(idx0), 32'd0);
      @(negedge clk);
      run(2);
      rst = 1'b0;
      run(13);
      for (int p = 0; p < N; p++) begin
         rst = 1'b1;
         run(1 + (p % 2));
         rst = 1'b0;
         run(p + 1);
      end
      run(40);
      rst = 1'b1;
      run(1);
      rst = 1'b0;
      run(9);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 5000 && !done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule